// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver with Flow Control

This block moves eight-bit words over a three-wire synchronous link: a transfer clock, a data output and a data input. Each word is shifted least significant bit first. The output data changes on the falling edge of the transfer clock, and the input data is captured on the rising edge. Software places a byte in a one-entry transmit buffer. The block moves it into the shift register as soon as the shift register is free, and then raises a transmit interrupt request. When a word has been received in full, it lands in a receive buffer, a full flag sets and a receive interrupt request is raised.

The link runs in one of two clock modes. In the internal mode the block is the clock master. It divides the system clock so that each transfer clock period lasts 2(n+1) system cycles, where n comes from `div_n`. An active-low clear-to-send input and the transmit enable freeze the divider at any point, including in the middle of a word. In the external mode a remote master supplies the clock. The block synchronises that clock and the input data through two flip-flops and acts on the edges it detects. It drives an active-low ready-to-send output to tell the master when it may clock the next word.

Receiving always needs a transmit: a dummy byte written to the transmit buffer is what arms a frame. Both interrupt requests stay set until they are acknowledged.

Top module: `sync_serial_port`

## Requirements
- R1: In internal mode (`ext_clk_mode`=0), `sclk_out` stays low for exactly `div_n`+1 system cycles once it falls, and stays high for `div_n`+1 cycles between the falling edges of a word, so each transfer clock period is 2(`div_n`+1) cycles.
- R2: A word is DATA_W bits long. `tx_data` bit 0 appears first on `sdo`. The first bit received on `sdi` becomes bit 0 of `rx_data`.
- R3: `sclk_out` idles high. `sdo` changes only at a falling edge of the transfer clock. `sdi` is sampled at the rising edge. `sdo` is 1 after reset.
- R4: In internal mode, while `cts_n`=1 or `tx_en`=0, no word starts and the transfer clock holds its level, even in the middle of a word. The word resumes when both conditions clear.
- R5: A byte in the transmit buffer moves to the shift register when the shift register is free, `tx_en`=1 and (in internal mode) `cts_n`=0. At that moment `tx_empty` rises and `tx_irq` sets. A second byte may be buffered during a transfer, and it is sent right after the first.
- R6: When the last bit of a word is sampled with `rx_en`=1, `rx_data` takes the word, `rx_full` sets and `rx_irq` sets. A one-cycle pulse on `rx_rd` clears `rx_full`.
- R7: In external mode, `rts_n` goes low when a dummy byte is loaded while `rx_en`=1 and `rx_full`=0. It goes high at the first rising clock edge of a word, stays high when the word completes, and goes low when `rx_rd` clears `rx_full`. In internal mode `rts_n` is 1.
- R8: `tx_idle` is 1 only when both the transmit buffer and the shift register are empty.
- R9: `tx_irq` and `rx_irq` stay set until `tx_irq_ack` or `rx_irq_ack`, respectively, is pulsed.
- R10: A word that completes while `rx_en`=0 is not stored: `rx_full` and `rx_irq` stay 0.
- R11: A `tx_wr` while the transmit buffer is full (`tx_empty`=0) is ignored. The byte already buffered is the one sent, and nothing extra stays pending afterwards.
- R12: In external mode (`ext_clk_mode`=1), bits are shifted on the edges of `sclk_in` after a two-flip-flop synchroniser on both `sclk_in` and `sdi`. `sclk_in` must idle high and run at no more than one sixth of `clk`.
- R13: After reset: `tx_empty`=1, `tx_idle`=1, `rx_full`=0, `sclk_out`=1, `sdo`=1, `rts_n`=1, and both interrupt requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the divider's count source |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_clk_mode | input | 1 | 1 = transfer clock comes from `sclk_in`, 0 = generated internally |
| div_n | input | DIV_W | Divider value n, giving a clock period of 2(n+1) cycles |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| cts_n | input | 1 | Active-low clear-to-send, used in internal mode |
| rts_n | output | 1 | Active-low ready-to-send, driven in external mode |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_data | input | DATA_W | Byte to write to the transmit buffer |
| tx_empty | output | 1 | Transmit buffer holds no byte |
| tx_idle | output | 1 | Transmit buffer and shift register are both empty |
| rx_rd | input | 1 | Read strobe, clears the receive-full flag |
| rx_data | output | DATA_W | Receive buffer contents |
| rx_full | output | 1 | Receive buffer holds an unread word |
| tx_irq | output | 1 | Sticky transmit interrupt request |
| tx_irq_ack | input | 1 | Clears `tx_irq` |
| rx_irq | output | 1 | Sticky receive interrupt request |
| rx_irq_ack | input | 1 | Clears `rx_irq` |
| sclk_out | output | 1 | Transfer clock in internal mode, held high otherwise |
| sclk_in | input | 1 | Transfer clock from the remote master |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The hardest case to reach from the ports is a transfer clock frozen in the middle of a word. It needs a running frame, and then a change to `cts_n` or `tx_en` in a chosen half period. The bench runs a slave model that answers every clock edge. A parallel branch counts falling edges of `sclk_out`: it raises `cts_n` after the first falling edge and drops `tx_en` after the fourth. At each stop it checks that the clock holds low and that the word still arrives intact. The ready-to-send sequence in external mode is reached the same way. The bench acts as the clock master and samples `rts_n` after the dummy load, after the first rising edge, at completion and after the read.

// File: rtl/sync_serial_port.sv
`timescale 1ns/1ps
module sync_serial_port #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clk_mode,
  input  logic [DIV_W-1:0]  div_n,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              cts_n,
  output logic              rts_n,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_empty,
  output logic              tx_idle,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              tx_irq,
  input  logic              tx_irq_ack,
  output logic              rx_irq,
  input  logic              rx_irq_ack,
  output logic              sclk_out,
  input  logic              sclk_in,
  output logic              sdo,
  input  logic              sdi
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] tbuf, tsh, rsh, rbuf;
  logic              tbuf_full, busy, sclk_q, sdo_q, rts_q, full_q, tirq_q, rirq_q;
  logic [DIV_W-1:0]  hcnt;
  logic [CNT_W-1:0]  bits;
  logic [2:0]        ck_sync;
  logic [1:0]        dt_sync;

  wire run      = tx_en & ~cts_n;
  wire tick     = ~ext_clk_mode & busy & run & (hcnt == div_n);
  wire ext_fall = ext_clk_mode & busy & ck_sync[2] & ~ck_sync[1];
  wire ext_rise = ext_clk_mode & busy & ~ck_sync[2] & ck_sync[1];
  wire fall_ev  = ext_fall | (tick & sclk_q);
  wire rise_ev  = ext_rise | (tick & ~sclk_q);
  wire in_bit   = ext_clk_mode ? dt_sync[1] : sdi;
  wire last     = rise_ev & (bits == CNT_W'(DATA_W - 1));
  wire store    = last & rx_en;
  wire load     = ~busy & tbuf_full & tx_en & (ext_clk_mode | ~cts_n);
  wire wr_ok    = tx_wr & ~tbuf_full;
  wire [DATA_W-1:0] rsh_next = {in_bit, rsh[DATA_W-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ck_sync <= '1;
      dt_sync <= '1;
    end else begin
      ck_sync <= {ck_sync[1:0], sclk_in};
      dt_sync <= {dt_sync[0], sdi};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbuf      <= '0;
      tbuf_full <= 1'b0;
    end else if (wr_ok) begin
      tbuf      <= tx_data;
      tbuf_full <= 1'b1;
    end else if (load) begin
      tbuf_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      sclk_q <= 1'b1;
      hcnt   <= '0;
      bits   <= '0;
      tsh    <= '0;
      rsh    <= '0;
      sdo_q  <= 1'b1;
    end else begin
      if (load) begin
        busy <= 1'b1;
        tsh  <= tbuf;
        bits <= '0;
        hcnt <= '0;
      end else begin
        if (last) busy <= 1'b0;
        if (tick) begin
          hcnt   <= '0;
          sclk_q <= ~sclk_q;
        end else if (busy & run & ~ext_clk_mode) begin
          hcnt <= hcnt + 1'b1;
        end
        if (fall_ev) begin
          sdo_q <= tsh[0];
          tsh   <= tsh >> 1;
        end
        if (rise_ev) begin
          rsh  <= rsh_next;
          bits <= bits + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rbuf   <= '0;
      full_q <= 1'b0;
    end else if (store) begin
      rbuf   <= rsh_next;
      full_q <= 1'b1;
    end else if (rx_rd) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                    rts_q <= 1'b1;
    else if (!ext_clk_mode)                        rts_q <= 1'b1;
    else if (rise_ev && bits == '0)                rts_q <= 1'b1;
    else if (load && rx_en && !full_q)             rts_q <= 1'b0;
    else if (rx_rd && full_q && !store)            rts_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tirq_q <= 1'b0;
      rirq_q <= 1'b0;
    end else begin
      if (load)            tirq_q <= 1'b1;
      else if (tx_irq_ack) tirq_q <= 1'b0;
      if (store)           rirq_q <= 1'b1;
      else if (rx_irq_ack) rirq_q <= 1'b0;
    end
  end

  assign sclk_out = ext_clk_mode ? 1'b1 : sclk_q;
  assign sdo      = sdo_q;
  assign rts_n    = rts_q;
  assign tx_empty = ~tbuf_full;
  assign tx_idle  = ~tbuf_full & ~busy;
  assign rx_data  = rbuf;
  assign rx_full  = full_q;
  assign tx_irq   = tirq_q;
  assign rx_irq   = rirq_q;
endmodule

// File: rtl/sync_serial_port_chk.sv
`timescale 1ns/1ps
module sync_serial_port_chk (
  input logic clk,
  input logic rst_n,
  input logic ext_clk_mode,
  input logic tx_en,
  input logic rx_en,
  input logic cts_n,
  input logic rts_n,
  input logic tx_empty,
  input logic tx_idle,
  input logic rx_full,
  input logic tx_irq,
  input logic tx_irq_ack,
  input logic rx_irq,
  input logic rx_irq_ack,
  input logic sclk_out,
  input logic sdo
);
  assert_sdo_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_clk_mode && $stable(ext_clk_mode) && !$stable(sdo)) |-> $fell(sclk_out));

  assert_clock_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_clk_mode && $past(!ext_clk_mode) && $past(cts_n || !tx_en)) |-> $stable(sclk_out));

  assert_load_raises_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_empty) |-> tx_irq);

  assert_store_raises_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> rx_irq);

  assert_rts_held_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_clk_mode && $stable(ext_clk_mode) && $rose(rx_full)) |-> rts_n);

  assert_rts_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_clk_mode && $stable(ext_clk_mode) && $fell(rx_full)) |-> !rts_n);

  assert_rts_internal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_clk_mode && $past(!ext_clk_mode)) |-> rts_n);

  assert_idle_needs_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> tx_empty);

  assert_tx_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq && !tx_irq_ack) |=> tx_irq);

  assert_rx_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq && !rx_irq_ack) |=> rx_irq);

  assert_store_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(rx_en));
endmodule

bind sync_serial_port sync_serial_port_chk u_chk (.*);

// File: tb/sync_serial_port_test.sv
`timescale 1ns/1ps
module sync_serial_port_test;
  logic clk = 0, rst_n = 0, ext_clk_mode = 0, tx_en = 1, rx_en = 1, cts_n = 0;
  logic [7:0] div_n = 0, tx_data = 0;
  logic tx_wr = 0, rx_rd = 0, tx_irq_ack = 0, rx_irq_ack = 0, sclk_in = 1, sdi = 1;
  logic rts_n, tx_empty, tx_idle, rx_full, tx_irq, rx_irq, sclk_out, sdo;
  logic [7:0] rx_data;
  int n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  sync_serial_port uut (.*);

  localparam logic [23:0] VEC [0:3] = '{24'h00_3C_A5, 24'h01_81_5E, 24'h03_FF_00, 24'h06_6B_D2};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_tx(input logic [7:0] d);
    @(negedge clk); tx_wr = 1; tx_data = d;
    @(negedge clk); tx_wr = 0;
  endtask

  task automatic pulse_rd_ack();
    @(negedge clk); rx_rd = 1; tx_irq_ack = 1; rx_irq_ack = 1;
    @(negedge clk); rx_rd = 0; tx_irq_ack = 0; rx_irq_ack = 0;
  endtask

  task automatic slave_int(input logic [7:0] rx_b, output logic [7:0] got, input int n, input bit chk_per);
    realtime tf;
    for (int i = 0; i < 8; i++) begin
      @(negedge sclk_out); tf = $realtime;
      #1 sdi = rx_b[i];
      @(posedge sclk_out);
      if (i == 0 && chk_per) chk("R1 low phase ns", int'($realtime - tf), (n + 1) * 10);
      got[i] = sdo;
    end
  endtask

  task automatic master_ext(input logic [7:0] rx_b, output logic [7:0] got);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); sclk_in = 0; sdi = rx_b[i];
      repeat (8) @(negedge clk);
      got[i] = sdo;
      sclk_in = 1;
      repeat (8) @(negedge clk);
      if (i == 0) chk("R7 rts high after first rise", rts_n, 1);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] got, got2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R13 tx_empty", tx_empty, 1);
    chk("R13 tx_idle", tx_idle, 1);
    chk("R13 rx_full", rx_full, 0);
    chk("R13 sclk_out idle", sclk_out, 1);
    chk("R13 sdo", sdo, 1);
    chk("R13 rts_n", rts_n, 1);
    chk("R13 irqs", {tx_irq, rx_irq}, 0);

    for (int v = 0; v < 4; v++) begin
      div_n = VEC[v][23:16];
      wr_tx(VEC[v][15:8]);
      slave_int(VEC[v][7:0], got, int'(VEC[v][23:16]), 1);
      @(negedge clk);
      chk("R2 tx bits lsb first", got, VEC[v][15:8]);
      chk("R2 R6 rx_data", rx_data, VEC[v][7:0]);
      chk("R6 rx_full", rx_full, 1);
      chk("R6 rx_irq", rx_irq, 1);
      chk("R5 tx_irq", tx_irq, 1);
      chk("R8 tx_idle after frame", tx_idle, 1);
      chk("R3 sclk_out idle high", sclk_out, 1);
      repeat (10) @(negedge clk);
      chk("R9 irqs held", {tx_irq, rx_irq}, 2'b11);
      pulse_rd_ack();
      chk("R6 rx_full cleared", rx_full, 0);
      chk("R9 irqs acked", {tx_irq, rx_irq}, 0);
    end

    div_n = 2;
    cts_n = 1;
    wr_tx(8'h96);
    wr_tx(8'h11);
    repeat (20) @(negedge clk);
    chk("R4 no start under cts", tx_empty, 0);
    chk("R4 clock idle under cts", sclk_out, 1);
    chk("R11 buffer still full", tx_empty, 0);
    cts_n = 0;
    slave_int(8'h3A, got, 2, 1);
    @(negedge clk);
    chk("R11 first byte sent", got, 8'h96);
    chk("R11 nothing pending", tx_idle, 1);
    pulse_rd_ack();

    wr_tx(8'hC3);
    fork
      slave_int(8'h5B, got, 2, 0);
      begin
        @(negedge sclk_out);
        @(negedge clk); cts_n = 1;
        repeat (20) @(negedge clk);
        chk("R4 frozen low on cts", sclk_out, 0);
        chk("R8 busy not idle", tx_idle, 0);
        cts_n = 0;
        repeat (3) @(negedge sclk_out);
        @(negedge clk); tx_en = 0;
        repeat (20) @(negedge clk);
        chk("R4 frozen low on tx_en", sclk_out, 0);
        tx_en = 1;
      end
    join
    @(negedge clk);
    chk("R4 tx after pauses", got, 8'hC3);
    chk("R4 rx after pauses", rx_data, 8'h5B);
    pulse_rd_ack();

    div_n = 3;
    wr_tx(8'h12);
    wait (tx_empty == 1);
    @(negedge clk);
    wr_tx(8'hE7);
    chk("R8 not idle with shift busy", tx_idle, 0);
    slave_int(8'h00, got, 3, 0);
    slave_int(8'hFF, got2, 3, 0);
    @(negedge clk);
    chk("R5 back-to-back first", got, 8'h12);
    chk("R5 back-to-back second", got2, 8'hE7);
    pulse_rd_ack();

    rx_en = 0;
    wr_tx(8'h44);
    slave_int(8'h99, got, 3, 0);
    repeat (3) @(negedge clk);
    chk("R10 not stored", {rx_full, rx_irq}, 0);
    rx_en = 1;
    pulse_rd_ack();

    ext_clk_mode = 1;
    repeat (4) @(negedge clk);
    chk("R7 rts high before arm", rts_n, 1);
    chk("R12 sclk_out held high", sclk_out, 1);
    wr_tx(8'hA9);
    repeat (2) @(negedge clk);
    chk("R7 rts low when armed", rts_n, 0);
    master_ext(8'h6E, got);
    repeat (8) @(negedge clk);
    chk("R12 ext tx data", got, 8'hA9);
    chk("R12 ext rx data", rx_data, 8'h6E);
    chk("R6 ext rx_full", rx_full, 1);
    chk("R7 rts unchanged at completion", rts_n, 1);
    pulse_rd_ack();
    chk("R7 rts low after read", rts_n, 0);
    ext_clk_mode = 0;
    @(negedge clk);
    chk("R7 rts high in internal mode", rts_n, 1);

    finish_run();
  end
endmodule